// File: doc/BRIEF.md
# Third-Order Sigma-Delta Divide-Ratio Generator

This block produces, once per divided-feedback cycle, the whole-number ratio that a programmable feedback counter in a fractional-N synthesizer loads next. Over many cycles the average of those ratios equals INT + FRAC / 2^25. FRAC is a 25-bit word, so the modulus is fixed at 2^25 and each accumulator simply wraps at its natural width. INT is a 12-bit integer.

Three 25-bit accumulators are chained in cascade. The first adds FRAC, and each later stage adds the wrapped sum of the stage before it. Their overflow bits are merged with first- and second-difference terms into a signed offset between -3 and +4. This shapes the quantization error to third order, so the output wanders over several integers around INT rather than toggling between two. The offset is added to INT and registered on every feedback clock edge.

INT and FRAC sit in working registers that change only on a load strobe, and both always change together. A partial update on the inputs therefore never reaches the output. During reset the working registers track the inputs and the output equals the presented integer.

Top module: `sd_frac_divctl`

## Requirements
- R1: While `rst_n` is low, every clock edge clears all three accumulators and all carry delay stages, copies `int_i`/`frac_i` into the working registers and sets `div_o` to `int_i`.
- R2: `int_i` and `frac_i` are copied into the working registers only on an edge where `load_i` is high, and both are copied on the same edge. Changes on them without `load_i` have no effect on `div_o`.
- R3: `div_o` is (INT_W+1) bits wide and, after each edge out of reset, equals the working INT plus a signed offset in -3..+4, taken modulo 2^(INT_W+1).
- R4: With the working FRAC at zero and the accumulators clear, `div_o` stays equal to the working INT on every cycle.
- R5: Starting from reset, over 2^k cycles with FRAC a multiple of 2^(25-k), the sum of the offsets (`div_o` minus INT) lies within -1..+2 of FRAC·2^k/2^25.
- R6: After `load_i` is sampled on edge E, the value registered on edge E still uses the old INT. The value registered on edge E+1 uses the new INT.
- R7: For a general FRAC, the offsets cover a spread of at least 2 (at least three distinct output values). This shows third-order shaping rather than two-level dithering.
- R8: Over 2^16 cycles with FRAC = 12345·2^9, the summed offset stays within -1..+2 of 12345, so the long-run average tracks INT + FRAC/2^25.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided-feedback clock, one edge per reference comparison |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Copies int_i and frac_i into the working registers |
| int_i | input | 12 | Integer part of the divide ratio |
| frac_i | input | 25 | Fractional part, in units of 2^-25 |
| div_o | output | 13 | Divide value for the next feedback count |

## Verification
The assertions check on every edge that reset clears the accumulator state and forces the output to the presented integer. They also check that the working registers hold unless a load is sampled, that each output sits within -3..+4 of the integer in force the cycle before, and that a zero fraction on clear state gives exactly INT. Some properties span many cycles, and only the bench's scenarios can show them: the summed offset over a 2^k window, the long-run average, the multi-value spread of the third-order output, and the one-cycle latency of a load.

// File: rtl/sd_frac_divctl.sv
module sd_frac_divctl #(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 25,
  localparam int OUT_W = INT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [OUT_W-1:0]  div_o
);

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q, acc1, acc2, acc3;
  logic              cy2_d, cy3_d, cy3_dd;
  logic [FRAC_W:0]   sum1, sum2, sum3;
  logic [3:0]        offs;

  assign sum1 = {1'b0, acc1} + {1'b0, frac_q};
  assign sum2 = {1'b0, acc2} + {1'b0, sum1[FRAC_W-1:0]};
  assign sum3 = {1'b0, acc3} + {1'b0, sum2[FRAC_W-1:0]};

  // c1 + (c2 - c2') + (c3 - 2c3' + c3''), two's complement in 4 bits
  assign offs = 4'(sum1[FRAC_W]) + 4'(sum2[FRAC_W]) - 4'(cy2_d)
              + 4'(sum3[FRAC_W]) - {2'b00, cy3_d, 1'b0} + 4'(cy3_dd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q  <= int_i;
      frac_q <= frac_i;
      acc1   <= '0;
      acc2   <= '0;
      acc3   <= '0;
      cy2_d  <= 1'b0;
      cy3_d  <= 1'b0;
      cy3_dd <= 1'b0;
      div_o  <= {1'b0, int_i};
    end else begin
      if (load_i) begin
        int_q  <= int_i;
        frac_q <= frac_i;
      end
      acc1   <= sum1[FRAC_W-1:0];
      acc2   <= sum2[FRAC_W-1:0];
      acc3   <= sum3[FRAC_W-1:0];
      cy2_d  <= sum2[FRAC_W];
      cy3_d  <= sum3[FRAC_W];
      cy3_dd <= cy3_d;
      div_o  <= {1'b0, int_q} + {{(OUT_W-4){offs[3]}}, offs};
    end
  end

  // R1: reset clears state and forces the output to the presented integer
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (acc1 == '0 && acc2 == '0 && acc3 == '0 && !cy2_d && !cy3_d && !cy3_dd
                && div_o == {1'b0, $past(int_i)}));

  // R2: working values hold unless a load is sampled
  p_hold_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(int_q) && $stable(frac_q)));

  // R2: both halves are adopted on the same edge
  p_load_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (int_q == $past(int_i) && frac_q == $past(frac_i)));

  // R3: output within -3..+4 of the integer in force one cycle earlier
  p_offset_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((div_o - {1'b0, $past(int_q)}) + OUT_W'(3) <= OUT_W'(7)));

  // R4: zero fraction on clear state yields exactly INT
  p_zero_frac_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_q == '0 && acc1 == '0 && acc2 == '0 && acc3 == '0 && !cy2_d && !cy3_d && !cy3_dd)
      |=> div_o == {1'b0, $past(int_q)});

endmodule

// File: tb/sd_frac_divctl_tb_top.sv
module sd_frac_divctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [11:0] int_i = 12'd0;
  logic [24:0] frac_i = 25'd0;
  logic [12:0] div_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    kind;  // 0: single sample, 1: window sum, 2: window sum + spread
    int    n;
    int    base;
    int    lo;
    int    hi;
    string tag;
  } item_t;
  item_t q[$];

  sd_frac_divctl dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i),
    .int_i(int_i), .frac_i(frac_i), .div_o(div_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor
  int w_cnt = 0, w_sum = 0, w_min = 0, w_max = 0;
  bit w_range_bad = 1'b0;
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      int off;
      it = q[0];
      off = int'(div_o) - it.base;
      if (it.kind == 0) begin
        n_checks++;
        if (off != it.lo) begin
          n_fail++;
          $display("FAIL %s: div_o=%0d expected=%0d", it.tag, div_o, it.base + it.lo);
        end
        void'(q.pop_front());
      end else begin
        if (w_cnt == 0) begin w_min = off; w_max = off; w_range_bad = 1'b0; end
        w_sum += off;
        if (off < w_min) w_min = off;
        if (off > w_max) w_max = off;
        if (off < -3 || off > 4) w_range_bad = 1'b1;
        w_cnt++;
        if (w_cnt == it.n) begin
          n_checks++;
          if (w_sum < it.lo || w_sum > it.hi) begin
            n_fail++;
            $display("FAIL %s: offset sum=%0d expected %0d..%0d", it.tag, w_sum, it.lo, it.hi);
          end
          n_checks++;
          if (w_range_bad) begin
            n_fail++;
            $display("FAIL R3 window range: min=%0d max=%0d expected within -3..4", w_min, w_max);
          end
          if (it.kind == 2) begin
            n_checks++;
            if (w_max - w_min < 2) begin
              n_fail++;
              $display("FAIL R7 spread: actual=%0d expected>=2", w_max - w_min);
            end
          end
          w_cnt = 0;
          w_sum = 0;
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic push1(int base, int off, string tag);
    item_t it;
    it.kind = 0; it.n = 1; it.base = base; it.lo = off; it.hi = off; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic pushw(int kind, int n, int base, int lo, int hi, string tag);
    item_t it;
    it.kind = kind; it.n = n; it.base = base; it.lo = lo; it.hi = hi; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk); #1;
  endtask

  // reset with given values, release at negedge+1
  task automatic do_reset(int iv, int fv);
    @(negedge clk); #1;
    rst_n = 1'b0; int_i = 12'(iv); frac_i = 25'(fv);
    @(negedge clk); #1;
    rst_n = 1'b1;
  endtask

  // R5 window: 2^k cycles, FRAC = m * 2^(25-k), expected sum m in -1..+2
  task automatic window(int k, int m, int kind, string tag);
    do_reset(1000, m << (25 - k));
    pushw(kind, 1 << k, 1000, m - 1, m + 2, tag);
    drain();
  endtask

  initial begin
    // R1: output equals presented integer while in reset
    rst_n = 1'b0; int_i = 12'd100; frac_i = 25'd777;
    @(negedge clk); #1;
    push1(100, 0, "R1 reset output");
    drain();
    int_i = 12'd2345;
    push1(2345, 0, "R1 reset tracks int_i");
    drain();

    // R4: zero fraction keeps output at INT
    do_reset(1000, 0);
    for (int i = 0; i < 6; i++) push1(1000, 0, "R4 zero frac constant");
    drain();

    // R6: load latency, old INT on load edge, new INT one edge later
    int_i = 12'd2000; load_i = 1'b1;
    push1(1000, 0, "R6 load edge keeps old INT");
    push1(2000, 0, "R6 next edge uses new INT");
    @(negedge clk); #1;
    load_i = 1'b0;
    drain();

    // R2: input changes without load are ignored
    int_i = 12'd3000; frac_i = 25'd12345;
    for (int i = 0; i < 8; i++) push1(2000, 0, "R2 no load ignored");
    drain();

    // R5 windows and R3 range, R7 spread
    window(10, 1,    1, "R5 k=10 m=1");
    window(10, 517,  2, "R5 k=10 m=517");
    window(10, 1023, 1, "R5 k=10 m=1023");
    window(12, 2049, 2, "R5 k=12 m=2049");

    // R8: long run
    window(16, 12345, 2, "R8 k=16 m=12345");

    // R2: loaded fraction becomes active (sum reflects new FRAC), from zero state
    do_reset(1500, 0);
    frac_i = 25'(300 << 15); int_i = 12'd1500; load_i = 1'b1;
    @(negedge clk); #1;
    load_i = 1'b0;
    // first sample after load edge carries zero offset (state still clear)
    pushw(1, 1024, 1500, 299, 302, "R2 loaded FRAC takes effect");
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule